// File: doc/BRIEF.md
# Shared Data Port Access Decoder

This block turns the control pins of one shared, two-way data port into the strobes the two FIFOs behind that port need. One FIFO is the inbound FIFO, which takes writes from the port. The other is the outbound FIFO, which is read out onto the port. The block decodes a chip select (active low), a level-sensitive direction select, an enable and a mailbox select. It combines that decode with the inbound FIFO's ready flag and the outbound FIFO's data-available flag. From these it produces a one-cycle write strobe, a one-cycle read strobe, a mailbox-access strobe and the output enable for the tri-state data bus. The FIFO memories and the mailbox register are outside this block. All outputs are combinational, and the attached FIFOs sample them on the rising clock edge.

Each transfer direction follows valid/ready rules. The decoded request (chip selected, direction set, enabled, mailbox not selected) is the valid. The FIFO flag is the ready. A strobe fires only in a cycle where both are high. A request made while the flag is low is dropped and not held over. The host sees the flag and must present the request again. The parameter `READ_SEL_LEVEL` sets which level of the direction select means "read". The default of 0 suits the first port. A value of 1 gives the mirrored second port. The two port instances share no state, so each one works independently of activity on the other.

Top module: `port_access_decoder`

## Requirements
- R1: `bus_oe` is 1 exactly when `cs_n` is 0 and `rw_sel` equals `READ_SEL_LEVEL` (read direction). `port_en` and `mbx_sel` have no effect on it.
- R2: `in_wr_stb` is 1 exactly when `cs_n`=0, `rw_sel`≠`READ_SEL_LEVEL` (write direction), `port_en`=1, `mbx_sel`=0 and `in_ready`=1.
- R3: `out_rd_stb` is 1 exactly when `cs_n`=0, `rw_sel`=`READ_SEL_LEVEL`, `port_en`=1, `mbx_sel`=0 and `out_valid`=1.
- R4: A FIFO request whose flag (`in_ready` for writes, `out_valid` for reads) is 0 produces no strobe of any kind. The request is dropped with no retry.
- R5: When `mbx_sel`=1, neither FIFO strobe fires. `mbx_stb` is 1 exactly when `cs_n`=0, `port_en`=1 and `mbx_sel`=1. While `mbx_stb` is 1, `mbx_wr` is 1 for the write direction and 0 for the read direction.
- R6: With `cs_n`=1, every output (`bus_oe`, `in_wr_stb`, `out_rd_stb`, `mbx_stb`, `mbx_wr`) is 0.
- R7: With `port_en`=0, no strobe fires and `mbx_wr` is 0, while `bus_oe` still follows R1.
- R8: At most one of `in_wr_stb`, `out_rd_stb` and `mbx_stb` is 1 in any cycle. `bus_oe` and `in_wr_stb` are never both 1.
- R9: With `READ_SEL_LEVEL`=1, the meaning of `rw_sel` is mirrored: `rw_sel`=1 reads and drives the bus, and `rw_sel`=0 writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cs_n | input | 1 | Port select, active low |
| rw_sel | input | 1 | Direction select; the level equal to `READ_SEL_LEVEL` means read |
| port_en | input | 1 | Transfer enable |
| mbx_sel | input | 1 | Routes the access to the mailbox instead of a FIFO |
| in_ready | input | 1 | Inbound FIFO can accept a word |
| out_valid | input | 1 | Outbound FIFO holds a word to read |
| in_wr_stb | output | 1 | Write strobe into the inbound FIFO |
| out_rd_stb | output | 1 | Read strobe from the outbound FIFO |
| mbx_stb | output | 1 | Mailbox access strobe |
| mbx_wr | output | 1 | Direction of the mailbox access: 1 = write |
| bus_oe | output | 1 | Output enable for the tri-state data bus |

## Verification
The assertions check structural facts on every input change:
- No strobe fires without its flag, without chip select or without enable.
- The three strobes are mutually exclusive.
- The bus is never driven during a write strobe.
- A mailbox access suppresses both FIFO strobes.

Only the bench's scenarios can show the exact truth table: that each strobe does fire when every condition holds, and that `bus_oe` ignores enable and mailbox select. The bench also shows that the mirrored polarity really swaps read and write. It does this by sweeping every input combination on both the default and the mirrored instance.

// File: rtl/pac_pkg.sv
package pac_pkg;
  // Decoded transfer direction seen from the port.
  typedef enum logic {
    XFER_IN  = 1'b0,  // port drives data into the inbound FIFO
    XFER_OUT = 1'b1   // outbound FIFO drives data onto the port
  } xfer_dir_e;
endpackage

// File: rtl/pac_dir_decode.sv
module pac_dir_decode #(
  parameter bit READ_SEL_LEVEL = 1'b0
) (
  input  logic                 cs_n,
  input  logic                 rw_sel,
  output pac_pkg::xfer_dir_e   dir,
  output logic                 bus_oe
);
  import pac_pkg::*;

  // Polarity is fixed per port instance.
  generate
    if (READ_SEL_LEVEL) begin : g_read_high
      assign dir = rw_sel ? XFER_OUT : XFER_IN;
    end else begin : g_read_low
      assign dir = rw_sel ? XFER_IN : XFER_OUT;
    end
  endgenerate

  // The bus is driven whenever the port is selected for reading.
  assign bus_oe = !cs_n && (dir == XFER_OUT);
endmodule

// File: rtl/pac_cmd_qual.sv
module pac_cmd_qual (
  input  logic                cs_n,
  input  logic                port_en,
  input  logic                mbx_sel,
  input  pac_pkg::xfer_dir_e  dir,
  output logic                in_req,
  output logic                out_req,
  output logic                mbx_stb,
  output logic                mbx_wr
);
  import pac_pkg::*;

  logic active;

  assign active  = !cs_n && port_en;
  // FIFO requests (the "valid" side) exist only outside mailbox accesses.
  assign in_req  = active && !mbx_sel && (dir == XFER_IN);
  assign out_req = active && !mbx_sel && (dir == XFER_OUT);
  // The mailbox path takes over the cycle when selected.
  assign mbx_stb = active && mbx_sel;
  assign mbx_wr  = mbx_stb && (dir == XFER_IN);
endmodule

// File: rtl/pac_flow_gate.sv
module pac_flow_gate (
  input  logic req,
  input  logic ready,
  output logic fire
);
  // A request fires only with its flag; otherwise it is simply dropped.
  assign fire = req && ready;
endmodule

// File: rtl/port_access_decoder.sv
module port_access_decoder #(
  parameter bit READ_SEL_LEVEL = 1'b0
) (
  input  logic cs_n,
  input  logic rw_sel,
  input  logic port_en,
  input  logic mbx_sel,
  input  logic in_ready,
  input  logic out_valid,
  output logic in_wr_stb,
  output logic out_rd_stb,
  output logic mbx_stb,
  output logic mbx_wr,
  output logic bus_oe
);
  import pac_pkg::*;

  xfer_dir_e dir;
  logic      in_req;
  logic      out_req;

  pac_dir_decode #(.READ_SEL_LEVEL(READ_SEL_LEVEL)) u_dir (
    .cs_n   (cs_n),
    .rw_sel (rw_sel),
    .dir    (dir),
    .bus_oe (bus_oe)
  );

  pac_cmd_qual u_qual (
    .cs_n    (cs_n),
    .port_en (port_en),
    .mbx_sel (mbx_sel),
    .dir     (dir),
    .in_req  (in_req),
    .out_req (out_req),
    .mbx_stb (mbx_stb),
    .mbx_wr  (mbx_wr)
  );

  pac_flow_gate u_wr_gate (
    .req   (in_req),
    .ready (in_ready),
    .fire  (in_wr_stb)
  );

  pac_flow_gate u_rd_gate (
    .req   (out_req),
    .ready (out_valid),
    .fire  (out_rd_stb)
  );
endmodule

// File: rtl/port_access_decoder_chk.sv
module port_access_decoder_chk (
  input logic cs_n,
  input logic rw_sel,
  input logic port_en,
  input logic mbx_sel,
  input logic in_ready,
  input logic out_valid,
  input logic in_wr_stb,
  input logic out_rd_stb,
  input logic mbx_stb,
  input logic mbx_wr,
  input logic bus_oe
);
  always_comb begin
    // R2 and R4: a write strobe needs its flag
    p_wr_needs_ready_r4: assert (!in_wr_stb || in_ready)
      else $error("write strobe without in_ready");
    // R3 and R4: a read strobe needs data available
    p_rd_needs_valid_r3: assert (!out_rd_stb || out_valid)
      else $error("read strobe without out_valid");
    p_mbx_blocks_fifo_r5: assert (!mbx_sel || (!in_wr_stb && !out_rd_stb))
      else $error("FIFO strobe during mailbox select");
    p_deselect_idle_r6: assert (!cs_n || !(in_wr_stb || out_rd_stb || mbx_stb || mbx_wr || bus_oe))
      else $error("activity while deselected");
    p_enable_gates_r7: assert (port_en || !(in_wr_stb || out_rd_stb || mbx_stb))
      else $error("strobe while disabled");
    p_one_strobe_r8: assert ($onehot0({in_wr_stb, out_rd_stb, mbx_stb}))
      else $error("more than one strobe");
    p_no_drive_on_write_r8: assert (!(bus_oe && in_wr_stb))
      else $error("bus driven during write");
  end
endmodule

bind port_access_decoder port_access_decoder_chk u_chk (.*);

// File: tb/port_access_decoder_tb.sv
module port_access_decoder_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic cs_n, rw_sel, port_en, mbx_sel, in_ready, out_valid;
  logic a_wr, a_rd, a_mbx, a_mwr, a_oe;
  logic b_wr, b_rd, b_mbx, b_mwr, b_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  port_access_decoder #(.READ_SEL_LEVEL(1'b0)) u_dut (
    .cs_n(cs_n), .rw_sel(rw_sel), .port_en(port_en), .mbx_sel(mbx_sel),
    .in_ready(in_ready), .out_valid(out_valid),
    .in_wr_stb(a_wr), .out_rd_stb(a_rd), .mbx_stb(a_mbx), .mbx_wr(a_mwr), .bus_oe(a_oe)
  );

  port_access_decoder #(.READ_SEL_LEVEL(1'b1)) u_dut_b (
    .cs_n(cs_n), .rw_sel(rw_sel), .port_en(port_en), .mbx_sel(mbx_sel),
    .in_ready(in_ready), .out_valid(out_valid),
    .in_wr_stb(b_wr), .out_rd_stb(b_rd), .mbx_stb(b_mbx), .mbx_wr(b_mwr), .bus_oe(b_oe)
  );

  task automatic check(input logic got, input logic exp, input string tag, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b (cs_n=%b sel=%b en=%b mbx=%b rdy=%b vld=%b)",
               tag, what, got, exp, cs_n, rw_sel, port_en, mbx_sel, in_ready, out_valid);
    end
  endtask

  // Reason a FIFO strobe is expected low, most basic cause first.
  function automatic string why(input bit want_dir, input bit flag);
    if (cs_n)          return "R6";
    else if (!port_en) return "R7";
    else if (mbx_sel)  return "R5";
    else if (!want_dir) return "R8";
    else if (!flag)    return "R4";
    else               return "R2";
  endfunction

  task automatic check_port(input bit read_lvl, input logic wr, input logic rd,
                            input logic mb, input logic mw, input logic oe);
    bit    is_rd, act;
    bit    e_wr, e_rd, e_mb, e_mw, e_oe;
    string pre;
    pre   = read_lvl ? "R9/" : "";
    is_rd = (rw_sel == read_lvl);
    act   = !cs_n && port_en;
    e_oe  = !cs_n && is_rd;
    e_wr  = act && !mbx_sel && !is_rd && in_ready;
    e_rd  = act && !mbx_sel && is_rd && out_valid;
    e_mb  = act && mbx_sel;
    e_mw  = e_mb && !is_rd;
    check(oe, e_oe, {pre, cs_n ? "R6" : "R1"}, "bus_oe");
    check(wr, e_wr, {pre, e_wr ? "R2" : why(!is_rd, in_ready)}, "in_wr_stb");
    check(rd, e_rd, {pre, e_rd ? "R3" : why(is_rd, out_valid)}, "out_rd_stb");
    check(mb, e_mb, {pre, "R5"}, "mbx_stb");
    check(mw, e_mw, {pre, "R5"}, "mbx_wr");
    check(logic'($countones({wr, rd, mb}) <= 1), 1'b1, {pre, "R8"}, "strobe exclusivity");
  endtask

  initial begin
    // Idle start-up state: deselected port, R6.
    cs_n = 1'b1; rw_sel = 1'b0; port_en = 1'b0; mbx_sel = 1'b0;
    in_ready = 1'b0; out_valid = 1'b0;
    @(negedge clk); #1;
    check(a_oe | a_wr | a_rd | a_mbx | a_mwr, 1'b0, "R6", "idle outputs A");
    check(b_oe | b_wr | b_rd | b_mbx | b_mwr, 1'b0, "R6", "idle outputs B");
    // Exhaustive sweep of all 64 input combinations on both polarities.
    for (int v = 0; v < 64; v++) begin
      @(negedge clk);
      {cs_n, rw_sel, port_en, mbx_sel, in_ready, out_valid} = 6'(v);
      #1;
      check_port(1'b0, a_wr, a_rd, a_mbx, a_mwr, a_oe);
      check_port(1'b1, b_wr, b_rd, b_mbx, b_mwr, b_oe);
    end
    // Mirrored polarity on a full write: only the second instance reads (R9).
    @(negedge clk);
    {cs_n, rw_sel, port_en, mbx_sel, in_ready, out_valid} = 6'b0_1_1_0_1_1;
    #1;
    check(a_wr, 1'b1, "R2", "port A writes with sel=1");
    check(b_rd, 1'b1, "R9", "port B reads with sel=1");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule